// File: doc/BRIEF.md
# Predicated Vector Carry-Chain Adder

This block is the add-with-carry / subtract-with-carry datapath of a 128-bit vector unit. The vector is split into four 32-bit lanes, handled from lane 0 up to lane 3. The carry out of each lane feeds the carry in of the next lane. Subtraction is done by inverting the second operand and adding it with the carry.

A 16-bit per-byte predicate controls which bytes of the old destination are replaced by the result. The same predicate decides which lanes take part in the carry chain. A lane that is switched off passes the carry through unchanged.

The first carry into lane 0 is either a constant set by the operation or the stored carry flag. The final carry is written back into a 4-bit flag register. The two form bits are taken from an instruction word supplied by the decoder. A skipped-first-beat indication makes a fixed-carry operation fall back to the flag-carry behaviour. Result and flags are captured on a one-cycle valid strobe and held until the next one.

Top module: `vec_carry_chain_add`

## Requirements
- R1: On an add, lane e (result bits [32e+31:32e], e = 0..3) holds n + m + carry_in of that lane, modulo 2^32, where n is `src_n_i` and m is `src_m_i`.
- R2: On a subtract, lane e holds n + (bitwise NOT m) + carry_in of that lane, modulo 2^32.
- R3: Instruction word bit 28 selects subtract (1) or add (0). Bit 12 selects the fixed-carry form (1) or the flag-carry form (0). All other bits are ignored.
- R4: The carry into lane 0 depends on the form. In the flag-carry form it is the stored C flag. In the fixed-carry form it is 0 for add and 1 for subtract.
- R5: With `skip_first_i` high, a fixed-carry operation behaves exactly as the flag-carry form. This covers both the initial carry and the flag-update rule.
- R6: Lane e is active when predicate bit 4e is set. An active lane passes its bit-32 carry out to the next lane. An inactive lane passes its own carry in through unchanged.
- R7: Result byte k takes the computed byte when predicate bit k is set. Otherwise it takes byte k of `dst_old_i`.
- R8: The flags are `nzcv_o` = {N, Z, C, V}, with C in bit 1. They update when any lane is active or when the effective form is fixed-carry. An update clears N, Z and V and sets C to the carry leaving lane 3's position in the chain.
- R9: When no flag update occurs, `nzcv_o` keeps its previous value exactly.
- R10: Result and flags register only on a cycle with `valid_i` high, and hold otherwise. Reset clears both to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | One-cycle operation strobe |
| insn_i | input | 32 | Instruction word; bits 28 and 12 decoded |
| skip_first_i | input | 1 | First beat of the operation was skipped |
| src_n_i | input | 128 | First source vector |
| src_m_i | input | 128 | Second source vector |
| dst_old_i | input | 128 | Previous destination contents |
| pred_i | input | 16 | Per-byte predicate |
| result_o | output | 128 | Merged registered result |
| nzcv_o | output | 4 | Flag register {N,Z,C,V} |

## Verification
A wrong carry in the chain shows up in two places one cycle after the strobe. The upper lanes of `result_o` are off by one, and bit 1 of `nzcv_o` is wrong. A stale or wrongly updated carry flag stays hidden until a following flag-carry operation uses it. It then corrupts lane 0 of that operation's result. For this reason the bench runs operations back to back and tracks the flag across them. Faults in the byte merge appear at once as bytes that should have kept the old destination. Faults in lane activity can only be seen under partial predicates, especially when a lane's low byte is off but its other bytes are on.

// File: rtl/vcc_pkg.sv
package vcc_pkg;
  localparam int LANES    = 4;
  localparam int LANE_W   = 32;
  localparam int VEC_W    = LANES * LANE_W;
  localparam int LANE_B   = LANE_W / 8;
  localparam int BYTES    = VEC_W / 8;
  localparam int SUB_BIT  = 28;
  localparam int FIX_BIT  = 12;
  localparam int FLAG_C   = 1;

  typedef struct packed {
    logic sub;
    logic fixed;
  } op_t;

  function automatic op_t decode_op(input logic [31:0] insn);
    op_t o;
    o.sub   = insn[SUB_BIT];
    o.fixed = insn[FIX_BIT];
    return o;
  endfunction
endpackage

// File: rtl/vcc_lane.sv
module vcc_lane #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         inv_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] full;
  always_comb begin
    full   = {1'b0, a_i} + {1'b0, b_i ^ {W{inv_i}}} + {{W{1'b0}}, cin_i};
    sum_o  = full[W-1:0];
    cout_o = full[W];
  end
endmodule

// File: rtl/vcc_chain.sv
module vcc_chain
  import vcc_pkg::*;
(
  input  logic [VEC_W-1:0] n_i,
  input  logic [VEC_W-1:0] m_i,
  input  logic [BYTES-1:0] pred_i,
  input  logic             inv_i,
  input  logic             cin_i,
  output logic [VEC_W-1:0] sum_o,
  output logic             cout_o,
  output logic             any_act_o
);
  logic [LANES:0]   chain;
  logic [LANES-1:0] act;
  assign chain[0] = cin_i;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    logic co;
    assign act[e] = pred_i[e*LANE_B];
    vcc_lane #(.W(LANE_W)) u_lane (
      .a_i   (n_i[e*LANE_W +: LANE_W]),
      .b_i   (m_i[e*LANE_W +: LANE_W]),
      .inv_i (inv_i),
      .cin_i (chain[e]),
      .sum_o (sum_o[e*LANE_W +: LANE_W]),
      .cout_o(co)
    );
    // inactive lanes forward the carry untouched
    assign chain[e+1] = act[e] ? co : chain[e];
  end

  assign cout_o    = chain[LANES];
  assign any_act_o = |act;
endmodule

// File: rtl/vcc_merge.sv
module vcc_merge
  import vcc_pkg::*;
(
  input  logic [VEC_W-1:0] new_i,
  input  logic [VEC_W-1:0] old_i,
  input  logic [BYTES-1:0] pred_i,
  output logic [VEC_W-1:0] out_o
);
  for (genvar k = 0; k < BYTES; k++) begin : g_byte
    assign out_o[k*8 +: 8] = pred_i[k] ? new_i[k*8 +: 8] : old_i[k*8 +: 8];
  end
endmodule

// File: rtl/vec_carry_chain_add.sv
module vec_carry_chain_add
  import vcc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       insn_i,
  input  logic              skip_first_i,
  input  logic [127:0]      src_n_i,
  input  logic [127:0]      src_m_i,
  input  logic [127:0]      dst_old_i,
  input  logic [15:0]       pred_i,
  output logic [127:0]      result_o,
  output logic [3:0]        nzcv_o
);
  op_t        op;
  logic       fixed_eff, cin0, cout, any_act, upd;
  logic [VEC_W-1:0] sum, merged;

  assign op        = decode_op(insn_i);
  assign fixed_eff = op.fixed & ~skip_first_i;
  assign cin0      = fixed_eff ? op.sub : nzcv_o[FLAG_C];

  vcc_chain u_chain (
    .n_i      (src_n_i),
    .m_i      (src_m_i),
    .pred_i   (pred_i),
    .inv_i    (op.sub),
    .cin_i    (cin0),
    .sum_o    (sum),
    .cout_o   (cout),
    .any_act_o(any_act)
  );

  vcc_merge u_merge (
    .new_i (sum),
    .old_i (dst_old_i),
    .pred_i(pred_i),
    .out_o (merged)
  );

  assign upd = any_act | fixed_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      nzcv_o   <= '0;
    end else if (valid_i) begin
      result_o <= merged;
      if (upd) nzcv_o <= {2'b00, cout, 1'b0};
    end
  end

  always_comb begin
    for (int k = 0; k < BYTES; k++) begin
      if (!pred_i[k]) assert (merged[k*8 +: 8] == dst_old_i[k*8 +: 8]); // R7
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(nzcv_o))); // R10
  AST_NZV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && upd) |=> (nzcv_o[3] == 1'b0 && nzcv_o[2] == 1'b0 && nzcv_o[0] == 1'b0)); // R8
  AST_NO_UPD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !upd) |=> $stable(nzcv_o)); // R9
  AST_NO_LANE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pred_i == '0 && (!insn_i[FIX_BIT] || skip_first_i)) |=> $stable(nzcv_o)); // R5
  AST_FIXED_EMPTY_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pred_i == '0 && insn_i[FIX_BIT] && !skip_first_i) |=> (nzcv_o[FLAG_C] == $past(insn_i[SUB_BIT]))); // R4
endmodule

// File: tb/vec_carry_chain_add_test.sv
module vec_carry_chain_add_test;
  logic clk = 1'b0, rst_ni = 1'b0, valid = 1'b0, skip = 1'b0;
  logic [31:0]  insn = '0;
  logic [127:0] n = '0, m = '0, d = '0, res;
  logic [15:0]  pred = '0;
  logic [3:0]   nzcv;
  int checks = 0, fails = 0;
  logic [127:0] exp_res = '0;
  logic [3:0]   exp_nzcv = '0;

  always #2 clk = ~clk;

  vec_carry_chain_add uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .insn_i(insn),
    .skip_first_i(skip), .src_n_i(n), .src_m_i(m), .dst_old_i(d),
    .pred_i(pred), .result_o(res), .nzcv_o(nzcv)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, expv);
    end
  endtask

  // reference model of one operation, updates expected state
  task automatic model();
    logic sub_f, fix_f, c, upd;
    logic [32:0] s;
    sub_f = insn[28];
    fix_f = insn[12] && !skip;
    c = fix_f ? sub_f : exp_nzcv[1];
    upd = fix_f;
    for (int e = 0; e < 4; e++) begin
      s = {1'b0, n[32*e +: 32]} + {1'b0, (sub_f ? ~m[32*e +: 32] : m[32*e +: 32])} + 33'(c);
      for (int b = 0; b < 4; b++)
        exp_res[32*e + 8*b +: 8] = pred[4*e + b] ? s[8*b +: 8] : d[32*e + 8*b +: 8];
      if (pred[4*e]) begin c = s[32]; upd = 1'b1; end
    end
    if (upd) exp_nzcv = {2'b00, c, 1'b0};
  endtask

  task automatic run(input string tag, input logic [31:0] i_w, input logic sk,
                     input logic [127:0] nn, input logic [127:0] mm,
                     input logic [127:0] dd, input logic [15:0] pp);
    @(negedge clk);
    insn = i_w; skip = sk; n = nn; m = mm; d = dd; pred = pp; valid = 1'b1;
    model();
    @(negedge clk);
    valid = 1'b0;
    chk({tag, " result"}, res, exp_res);
    chk({tag, " flags"}, {124'd0, nzcv}, {124'd0, exp_nzcv});
  endtask

  localparam logic [31:0] ADD  = 32'h0;
  localparam logic [31:0] SUB  = 32'h1000_0000;
  localparam logic [31:0] ADDI = 32'h0000_1000;
  localparam logic [31:0] SUBI = 32'h1000_1000;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R10 reset result", res, '0);
    chk("R10 reset flags", {124'd0, nzcv}, '0);
    rst_ni = 1'b1;

    // R1 R6 R8: carry ripples lane 0 -> 3
    run("R1 R6 R8 ripple", ADDI, 1'b0, {{3{32'hffff_ffff}}, 32'hffff_ffff},
        {96'd0, 32'd1}, '0, 16'hffff);
    // R4: flag-carry add uses stored C=1
    run("R4 flag cin", ADD, 1'b0, {4{32'd5}}, {4{32'd7}}, '0, 16'hffff);
    // R2 R4: fixed subtract, cin=1, equal operands
    run("R2 R4 subi", SUBI, 1'b0, {4{32'h1234_5678}}, {4{32'h1234_5678}}, '0, 16'hffff);
    // R2: flag-carry subtract with borrow
    run("R2 sbc", SUB, 1'b0, {4{32'd3}}, {4{32'd9}}, '0, 16'hffff);
    // R9 R5: empty predicate, flag form -> no flag change
    run("R9 empty flag form", ADD, 1'b0, '1, '1, {4{32'hdead_beef}}, 16'h0000);
    // R4 R8: empty predicate, fixed form still writes C = constant
    run("R4 R8 empty fixed sub", SUBI, 1'b0, '1, '1, {4{32'hcafe_f00d}}, 16'h0000);
    run("R4 R8 empty fixed add", ADDI, 1'b0, '1, '1, {4{32'hcafe_f00d}}, 16'h0000);
    run("R1 set C", ADDI, 1'b0, {96'd0, 32'hffff_ffff}, {96'd0, 32'd1}, '0, 16'h000f);
    // R5: skipped first beat, fixed add takes stored C, empty pred keeps flags
    run("R5 skip fixed", ADDI, 1'b1, {4{32'd10}}, {4{32'd20}}, '0, 16'hfff0);
    run("R5 skip no update", SUBI, 1'b1, '0, '0, '0, 16'h0000);
    // R6 R7: lane 1 low byte off -> carry bypasses lane 1, other bytes written
    run("R6 R7 bypass", ADDI, 1'b0, {{3{32'h0000_0000}}, 32'hffff_ffff},
        {{3{32'hffff_ffff}}, 32'd1}, {4{32'h1111_1111}}, 16'hfffe & 16'hffee | 16'h0001);
    // R3: unrelated instruction bits ignored
    run("R3 other bits", SUB | 32'h0fff_efff ^ 32'h0000_1000, 1'b0, {4{32'd100}}, {4{32'd1}},
        '0, 16'hffff);
    // R10: idle cycles hold outputs
    @(negedge clk);
    n = '1; m = '1; d = '1; pred = '1; insn = SUBI;
    @(negedge clk);
    chk("R10 hold result", res, exp_res);
    chk("R10 hold flags", {124'd0, nzcv}, {124'd0, exp_nzcv});

    for (int it = 0; it < 300; it++) begin
      logic [31:0] iw;
      logic [15:0] pp;
      logic [127:0] nn, mm;
      iw = $urandom();
      case ($urandom_range(3))
        0: pp = 16'hffff;
        1: pp = 16'h0000;
        default: pp = 16'($urandom());
      endcase
      nn = {$urandom(), $urandom(), $urandom(), $urandom()};
      mm = ($urandom_range(3) == 0) ? ~nn : {$urandom(), $urandom(), $urandom(), $urandom()};
      run("R1 R2 R4 R6 R7 R8 R9 random", iw, 1'($urandom_range(1)), nn, mm,
          {$urandom(), $urandom(), $urandom(), $urandom()}, pp);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule